// File: doc/BRIEF.md
# Opcode-Hinted Branch Direction Predictor

This block guesses the direction and target of a branch at fetch time. Each opcode carries a programmable two-bit class. The class gives a default direction and says whether that default is fixed or can be overridden per location. Alongside every cached instruction word sits one flip bit. For the two overridable classes, a set flip bit reverses the default. When a branch resolves, the flip bit of its word is rewritten so that the next guess for that word repeats the outcome just seen.

The fetch unit presents an opcode, a cache word index, the fetch address and the predecoded branch offset. One cycle later the block returns a taken/not-taken guess and a target address. A refill port clears every flip bit of a replaced line, so the predictor falls back to the opcode default for that line. A table port programs the class of each opcode. Cache tags and instruction data are not held here.

Top module: `bp_hint_predictor`

## Requirements
- R1: After reset, predValid, predTaken and predTarget are 0, every opcode class is 00 and every flip bit is 0, so any lookup predicts not taken.
- R2: predValid is 1 exactly one cycle after a cycle with lkValid high and is 0 otherwise. predTaken and predTarget keep their values through cycles without a lookup.
- R3: Class 00 (never) always predicts not taken and class 01 (always) always predicts taken, whatever the flip bit of the word.
- R4: Class 10 (rarely) has default not taken and class 11 (normally) has default taken. For these two classes the guess is the default XOR the flip bit at lkIndex. Class bit 0 is the default direction and class bit 1 enables the flip bit.
- R5: A resolve sets the flip bit at rsIndex to rsTaken XOR bit 0 of the class of rsOpcode, so the next lookup of that word with an overridable class predicts rsTaken.
- R6: A word index is {line, word}, with the word in the low WORD_W bits. A refill clears the flip bits of all words of line rfLine.
- R7: When a refill and a resolve hit the same line in one cycle, the refill wins and the resolved word's flip bit ends at 0.
- R8: predTarget is lkPc plus the sign-extended lkOffset, modulo 2^ADDR_W.
- R9: A lookup uses the class table and flip bits as they stood before that cycle's table write, resolve and refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request |
| lkOpcode | input | OPC_W | Opcode of the fetched instruction |
| lkIndex | input | LINE_W+WORD_W | Cache word index of the fetched instruction |
| lkPc | input | ADDR_W | Fetch address |
| lkOffset | input | OFF_W | Predecoded signed branch offset |
| rsValid | input | 1 | Branch resolution strobe |
| rsOpcode | input | OPC_W | Opcode of the resolved branch |
| rsIndex | input | LINE_W+WORD_W | Cache word index of the resolved branch |
| rsTaken | input | 1 | Actual outcome |
| rfValid | input | 1 | Line refill strobe |
| rfLine | input | LINE_W | Line being replaced |
| tbWrite | input | 1 | Class table write strobe |
| tbOpcode | input | OPC_W | Opcode whose class is written |
| tbClass | input | 2 | New class |
| predValid | output | 1 | Prediction valid |
| predTaken | output | 1 | Predicted direction |
| predTarget | output | ADDR_W | Predicted target address |

## Verification
A wrong flip bit or a wrong class entry is invisible until the affected word is looked up. It then shows as a wrong predTaken one cycle after that lookup, and only when the opcode has an overridable class. The same holds for a flip bit that survives a refill or that takes a resolve meant for a colliding line. Because of this, the stimulus keeps the set of words and opcodes small, so that resolves, refills and lookups hit the same entries within a few cycles. A fault in the target adder shows on the first lookup whose offset is negative or whose sum wraps.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    CLS_NEVER    = 2'b00,
    CLS_ALWAYS   = 2'b01,
    CLS_RARELY   = 2'b10,
    CLS_NORMALLY = 2'b11
  } bpClass_e;

  typedef struct packed {
    logic tblWe;
    logic invWe;
    logic lineClr;
    logic lkCap;
  } bpStrobes_t;
endpackage

// File: rtl/bp_ctrl.sv
module bp_ctrl #(
  parameter int LINE_W = 6
) (
  input  logic              lkValid,
  input  logic              rsValid,
  input  logic [LINE_W-1:0] rsLine,
  input  logic              rfValid,
  input  logic [LINE_W-1:0] rfLine,
  input  logic              tbWrite,
  output bp_pkg::bpStrobes_t strb
);
  logic lineHit;

  always_comb begin
    lineHit      = rfValid && (rfLine == rsLine);
    strb.tblWe   = tbWrite;
    strb.lineClr = rfValid;
    // refill of the same line overrides the resolve (R7)
    strb.invWe   = rsValid && !lineHit;
    strb.lkCap   = lkValid;
  end
endmodule

// File: rtl/bp_datapath.sv
module bp_datapath #(
  parameter int OPC_W  = 6,
  parameter int LINE_W = 6,
  parameter int WORD_W = 2,
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  bp_pkg::bpStrobes_t       strb,
  input  logic [OPC_W-1:0]         lkOpcode,
  input  logic [LINE_W+WORD_W-1:0] lkIndex,
  input  logic [ADDR_W-1:0]        lkPc,
  input  logic [OFF_W-1:0]         lkOffset,
  input  logic [OPC_W-1:0]         rsOpcode,
  input  logic [LINE_W+WORD_W-1:0] rsIndex,
  input  logic                     rsTaken,
  input  logic [LINE_W-1:0]        rfLine,
  input  logic [OPC_W-1:0]         tbOpcode,
  input  logic [1:0]               tbClass,
  output logic                     predValid,
  output logic                     predTaken,
  output logic [ADDR_W-1:0]        predTarget
);
  localparam int IDX_W    = LINE_W + WORD_W;
  localparam int NUM_OPC  = 1 << OPC_W;
  localparam int NUM_IDX  = 1 << IDX_W;
  localparam int NUM_LINE = 1 << LINE_W;
  localparam int WPL      = 1 << WORD_W;
  localparam int EXT_W    = ADDR_W - OFF_W;

  logic [1:0]         classTbl [NUM_OPC];
  logic [NUM_IDX-1:0] invBits;

  logic [1:0]        lkCls;
  logic [1:0]        rsCls;
  logic              lkGuess;
  logic              rsFlip;
  logic [ADDR_W-1:0] offExt;
  logic [ADDR_W-1:0] lkTarget;

  always_comb begin
    lkCls    = classTbl[lkOpcode];
    rsCls    = classTbl[rsOpcode];
    lkGuess  = lkCls[1] ? (lkCls[0] ^ invBits[lkIndex]) : lkCls[0];
    rsFlip   = rsTaken ^ rsCls[0];
    offExt   = {{EXT_W{lkOffset[OFF_W-1]}}, lkOffset};
    lkTarget = lkPc + offExt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int o = 0; o < NUM_OPC; o++) classTbl[o] <= 2'b00;
    end else if (strb.tblWe) begin
      classTbl[tbOpcode] <= tbClass;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      invBits <= '0;
    end else begin
      if (strb.invWe) invBits[rsIndex] <= rsFlip;
      if (strb.lineClr) begin
        for (int l = 0; l < NUM_LINE; l++) begin
          if (rfLine == LINE_W'(l)) invBits[l*WPL +: WPL] <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      predValid  <= 1'b0;
      predTaken  <= 1'b0;
      predTarget <= '0;
    end else begin
      predValid <= strb.lkCap;
      if (strb.lkCap) begin
        predTaken  <= lkGuess;
        predTarget <= lkTarget;
      end
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.lkCap |=> predValid);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.lkCap |=> (!predValid && $stable(predTaken) && $stable(predTarget)));
  p_resolve_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.invWe |=> (invBits[$past(rsIndex)] == ($past(rsTaken) ^ $past(classTbl[rsOpcode][0]))));
  p_refill_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.lineClr |=> (invBits[{$past(rfLine), {WORD_W{1'b0}}} +: WPL] == '0));
  p_table_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.tblWe |=> (classTbl[$past(tbOpcode)] == $past(tbClass)));
  p_fixed_class_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lkCap && !lkCls[1]) |=> (predTaken == $past(lkCls[0])));
endmodule

// File: rtl/bp_hint_predictor.sv
module bp_hint_predictor #(
  parameter int OPC_W  = 6,
  parameter int LINE_W = 6,
  parameter int WORD_W = 2,
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     lkValid,
  input  logic [OPC_W-1:0]         lkOpcode,
  input  logic [LINE_W+WORD_W-1:0] lkIndex,
  input  logic [ADDR_W-1:0]        lkPc,
  input  logic [OFF_W-1:0]         lkOffset,
  input  logic                     rsValid,
  input  logic [OPC_W-1:0]         rsOpcode,
  input  logic [LINE_W+WORD_W-1:0] rsIndex,
  input  logic                     rsTaken,
  input  logic                     rfValid,
  input  logic [LINE_W-1:0]        rfLine,
  input  logic                     tbWrite,
  input  logic [OPC_W-1:0]         tbOpcode,
  input  logic [1:0]               tbClass,
  output logic                     predValid,
  output logic                     predTaken,
  output logic [ADDR_W-1:0]        predTarget
);
  localparam int IDX_W = LINE_W + WORD_W;

  bp_pkg::bpStrobes_t strb;
  logic [LINE_W-1:0]  rsLine;

  assign rsLine = rsIndex[IDX_W-1:WORD_W];

  bp_ctrl #(.LINE_W(LINE_W)) u_ctrl (
    .lkValid (lkValid),
    .rsValid (rsValid),
    .rsLine  (rsLine),
    .rfValid (rfValid),
    .rfLine  (rfLine),
    .tbWrite (tbWrite),
    .strb    (strb)
  );

  bp_datapath #(
    .OPC_W(OPC_W), .LINE_W(LINE_W), .WORD_W(WORD_W),
    .ADDR_W(ADDR_W), .OFF_W(OFF_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .lkOpcode   (lkOpcode),
    .lkIndex    (lkIndex),
    .lkPc       (lkPc),
    .lkOffset   (lkOffset),
    .rsOpcode   (rsOpcode),
    .rsIndex    (rsIndex),
    .rsTaken    (rsTaken),
    .rfLine     (rfLine),
    .tbOpcode   (tbOpcode),
    .tbClass    (tbClass),
    .predValid  (predValid),
    .predTaken  (predTaken),
    .predTarget (predTarget)
  );
endmodule

// File: tb/sim_bp_hint_predictor.sv
module sim_bp_hint_predictor;
  localparam int OPC_W  = 6;
  localparam int LINE_W = 6;
  localparam int WORD_W = 2;
  localparam int ADDR_W = 16;
  localparam int OFF_W  = 10;
  localparam int IDX_W  = LINE_W + WORD_W;
  localparam int NUM_OPC = 1 << OPC_W;
  localparam int NUM_IDX = 1 << IDX_W;
  localparam int WPL     = 1 << WORD_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lkValid = 0, rsValid = 0, rsTaken = 0, rfValid = 0, tbWrite = 0;
  logic [OPC_W-1:0]  lkOpcode = '0, rsOpcode = '0, tbOpcode = '0;
  logic [IDX_W-1:0]  lkIndex = '0, rsIndex = '0;
  logic [ADDR_W-1:0] lkPc = '0;
  logic [OFF_W-1:0]  lkOffset = '0;
  logic [LINE_W-1:0] rfLine = '0;
  logic [1:0]        tbClass = '0;
  logic              predValid, predTaken;
  logic [ADDR_W-1:0] predTarget;

  always #5 clk = ~clk;

  bp_hint_predictor #(
    .OPC_W(OPC_W), .LINE_W(LINE_W), .WORD_W(WORD_W),
    .ADDR_W(ADDR_W), .OFF_W(OFF_W)
  ) u0 (.*);

  int total = 0;
  int bad = 0;
  logic [1:0]        mTbl [NUM_OPC];
  logic              mInv [NUM_IDX];
  logic              expValid = 0, expTaken = 0;
  logic [ADDR_W-1:0] expTarget = '0;

  function automatic logic modelGuess(logic [OPC_W-1:0] op, logic [IDX_W-1:0] idx);
    return mTbl[op][1] ? (mTbl[op][0] ^ mInv[idx]) : mTbl[op][0];
  endfunction

  function automatic logic [ADDR_W-1:0] modelTarget(logic [ADDR_W-1:0] pc, logic [OFF_W-1:0] off);
    return pc + ADDR_W'($signed(off));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(
    input logic lv, input logic [OPC_W-1:0] lop, input logic [IDX_W-1:0] lidx,
    input logic [ADDR_W-1:0] pc, input logic [OFF_W-1:0] off,
    input logic rv, input logic [OPC_W-1:0] rop, input logic [IDX_W-1:0] ridx, input logic rt,
    input logic fv, input logic [LINE_W-1:0] fl,
    input logic tw, input logic [OPC_W-1:0] top, input logic [1:0] tc,
    input string req);
    lkValid = lv; lkOpcode = lop; lkIndex = lidx; lkPc = pc; lkOffset = off;
    rsValid = rv; rsOpcode = rop; rsIndex = ridx; rsTaken = rt;
    rfValid = fv; rfLine = fl; tbWrite = tw; tbOpcode = top; tbClass = tc;
    expValid = lv;
    if (lv) begin
      expTaken  = modelGuess(lop, lidx);
      expTarget = modelTarget(pc, off);
    end
    if (rv && !(fv && fl == ridx[IDX_W-1:WORD_W])) mInv[ridx] = rt ^ mTbl[rop][0];
    if (fv) for (int w = 0; w < WPL; w++) mInv[{fl, WORD_W'(w)}] = 1'b0;
    if (tw) mTbl[top] = tc;
    @(posedge clk);
    @(negedge clk);
    lkValid = 0; rsValid = 0; rfValid = 0; tbWrite = 0;
    chk({req, " valid"}, 32'(predValid), 32'(expValid));
    chk({req, " taken"}, 32'(predTaken), 32'(expTaken));
    chk({req, " target"}, 32'(predTarget), 32'(expTarget));
  endtask

  task automatic look(logic [OPC_W-1:0] op, logic [IDX_W-1:0] idx, string req);
    step(1, op, idx, 16'h0100, '0, 0, '0, '0, 0, 0, '0, 0, '0, 2'b00, req);
  endtask

  task automatic resolve(logic [OPC_W-1:0] op, logic [IDX_W-1:0] idx, logic t, string req);
    step(0, '0, '0, '0, '0, 1, op, idx, t, 0, '0, 0, '0, 2'b00, req);
  endtask

  task automatic prog(logic [OPC_W-1:0] op, logic [1:0] c, string req);
    step(0, '0, '0, '0, '0, 0, '0, '0, 0, 0, '0, 1, op, c, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int o = 0; o < NUM_OPC; o++) mTbl[o] = 2'b00;
    for (int i = 0; i < NUM_IDX; i++) mInv[i] = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 reset valid", 32'(predValid), 0);
    chk("R1 reset taken", 32'(predTaken), 0);
    chk("R1 reset target", 32'(predTarget), 0);
    look(6'd5, 8'd3, "R1 lookup after reset");

    prog(6'd1, 2'b01, "R3 program always");
    prog(6'd2, 2'b00, "R3 program never");
    prog(6'd3, 2'b10, "R4 program rarely");
    prog(6'd4, 2'b11, "R4 program normally");

    // R3 fixed classes ignore a set flip bit
    resolve(6'd1, 8'd8, 1'b0, "R3 resolve always");
    look(6'd1, 8'd8, "R3 always with flip set");
    resolve(6'd2, 8'd9, 1'b1, "R3 resolve never");
    look(6'd2, 8'd9, "R3 never with flip set");

    // R4 defaults, R5 last outcome repeats
    look(6'd3, 8'd10, "R4 rarely default");
    resolve(6'd3, 8'd10, 1'b1, "R5 resolve rarely taken");
    look(6'd3, 8'd10, "R5 rarely repeats taken");
    look(6'd4, 8'd11, "R4 normally default");
    resolve(6'd4, 8'd11, 1'b0, "R5 resolve normally not taken");
    look(6'd4, 8'd11, "R5 normally repeats not taken");

    // R6 refill clears line 2 (words 8..11)
    step(0, '0, '0, '0, '0, 0, '0, '0, 0, 1, 6'd2, 0, '0, 2'b00, "R6 refill line");
    look(6'd3, 8'd10, "R6 rarely after refill");
    look(6'd4, 8'd11, "R6 normally after refill");

    // R7 refill and resolve on the same line
    step(0, '0, '0, '0, '0, 1, 6'd3, 8'd12, 1'b1, 1, 6'd3, 0, '0, 2'b00, "R7 collision");
    look(6'd3, 8'd12, "R7 refill wins");

    // R9 same-cycle ordering
    step(1, 6'd5, 8'd0, 16'h0100, '0, 0, '0, '0, 0, 0, '0, 1, 6'd5, 2'b01, "R9 lookup during table write");
    look(6'd5, 8'd0, "R9 lookup after table write");
    step(1, 6'd3, 8'd13, 16'h0100, '0, 1, 6'd3, 8'd13, 1'b1, 0, '0, 0, '0, 2'b00, "R9 lookup during resolve");
    look(6'd3, 8'd13, "R9 lookup after resolve");

    // R8 target arithmetic
    step(1, 6'd1, 8'd0, 16'hFFF0, 10'h020, 0, '0, '0, 0, 0, '0, 0, '0, 2'b00, "R8 wrap");
    step(1, 6'd1, 8'd0, 16'h0100, 10'h3F0, 0, '0, '0, 0, 0, '0, 0, '0, 2'b00, "R8 negative offset");
    // R2 hold without lookup
    step(0, '0, '0, 16'h1234, 10'h155, 0, '0, '0, 0, 0, '0, 0, '0, 2'b00, "R2 idle hold");

    // constrained random mix on a small set of words and opcodes
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      logic [OPC_W-1:0] lo, ro, to;
      logic [IDX_W-1:0] li, ri;
      lo = OPC_W'($urandom % 8); ro = OPC_W'($urandom % 8); to = OPC_W'($urandom % 8);
      li = IDX_W'($urandom % 16); ri = IDX_W'($urandom % 16);
      step($urandom % 4 != 0, lo, li, ADDR_W'($urandom), OFF_W'($urandom),
           $urandom % 2 == 0, ro, ri, 1'($urandom),
           $urandom % 16 == 0, LINE_W'($urandom % 4),
           $urandom % 32 == 0, to, 2'($urandom),
           "R4 R5 R6 R7 R8 R9 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule